// File: doc/BRIEF.md
# Pin Interrupt Sensing Controller

The controller watches 32 interrupt lines taken from two 16-pin GPIO ports, called port A and port B. The 32 sensed bits form four 8-bit byte lanes. An assignment register picks, for each lane, which port supplies the pins. The even lanes (0 and 2) always take the lower half of a port. The odd lanes (1 and 3) always take the upper half. So a 16-bit port is steered into either the low or the high half of the sensed word by writing the same select code into both bytes of that half.

Each routed pin goes through a two-flop synchroniser and then an optional polarity inversion. After that it is sensed as either a rising edge or an active-high level. Detected events set sticky request bits. A mask enables each bit individually, and a single interrupt output is the OR of every request bit whose mask bit is set. Falling-edge and active-low triggers are made by inverting the pin. Both-edge sensing is made by software flipping the invert bit after each acknowledge.

Software uses a 32-bit write bus with a combinational read port that shares the same address. The mask, edge and invert controls each have a set alias and a clear alias. The request register is write-one-to-clear.

Top module: `pint_ctrl`

## Requirements
- R1: After reset, mask, edge, invert, assignment and request registers all read 0 and `irq_o` is 0.
- R2: Lane k occupies sensed bits [8k+7:8k]. It takes pins [7:0] of a port when k is even and pins [15:8] when k is odd. Bit 8k of the assignment register (address 0x3, read/write) selects port B when 1 and port A when 0.
- R3: An edge-mode bit sets its request on the third rising clock edge after the pin changes so that the sensed value goes 0 to 1. A 1 to 0 change of the sensed value sets nothing.
- R4: The sensed value is the routed pin XOR the invert bit. With invert set, a falling pin raises a request and a rising pin does not. Setting invert while the pin is low is itself a 0 to 1 change.
- R5: Mask is set at 0x0 and cleared at 0x1, edge at 0x4/0x5, and invert at 0x6/0x7. Only the written 1 bits change. Reading either alias returns the register value. Unmapped addresses read 0.
- R6: Writing 1 to a bit at address 0x2 clears that pending request when no new event is present. Address 0x2 reads back the request register.
- R7: A level-mode bit (edge bit 0) stays requested while its sensed value is 1, and a clear write has no effect then. Once the sensed value is 0, the clear takes effect.
- R8: A new event in the same cycle as a clear write to that bit leaves the bit set. Other cleared bits still clear.
- R9: `irq_o` is 1 exactly when some bit has both request and mask set. Masked requests stay pending and readable.
- R10: Both-edge operation works as follows. Flipping the invert bit while the pin holds its level creates no request, and the next opposite pin transition raises one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_a_i | input | 16 | Pins of port A |
| port_b_i | input | 16 | Pins of port B |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address (write and read) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that the write strobe, address and data are all defined from the first clock after reset. They also assume that pin inputs only contain known values, since an X would spread through the invert and event terms into the request register. The bench drives every input from time zero and changes pins and bus signals only on falling clock edges. It holds each pin level for at least three cycles before it checks a result. This keeps every sensed transition separate from the next.

// File: rtl/pint_pkg.sv
`timescale 1ns/1ps
package pint_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    ADR_MSK_SET = 4'h0,
    ADR_MSK_CLR = 4'h1,
    ADR_REQ     = 4'h2,
    ADR_ASG     = 4'h3,
    ADR_EDG_SET = 4'h4,
    ADR_EDG_CLR = 4'h5,
    ADR_INV_SET = 4'h6,
    ADR_INV_CLR = 4'h7
  } reg_addr_e;
endpackage

// File: rtl/pint_sync.sv
`timescale 1ns/1ps
module pint_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pint_router.sv
`timescale 1ns/1ps
module pint_router #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic [2*LANE_W-1:0]     port_a_i,
  input  logic [2*LANE_W-1:0]     port_b_i,
  input  logic [LANES-1:0]        sel_i,
  output logic [LANES*LANE_W-1:0] lanes_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HALF = k % 2;  // even lanes: low half, odd lanes: high half
    assign lanes_o[k*LANE_W +: LANE_W] = sel_i[k] ? port_b_i[HALF*LANE_W +: LANE_W]
                                                  : port_a_i[HALF*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/pint_sense.sv
`timescale 1ns/1ps
module pint_sense #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lanes_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] inv_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] req_o
);
  logic [W-1:0] sens, sens_q, evt, req_q;

  assign sens = lanes_i ^ inv_i;
  assign evt  = (edge_i & sens & ~sens_q) | (~edge_i & sens);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sens_q <= '0;
      req_q  <= '0;
    end else begin
      sens_q <= sens;
      req_q  <= (req_q & ~clr_i) | evt;  // new event wins over clear
    end
  end

  assign req_o = req_q;

  p_edge_needs_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q & ~$past(req_q) & $past(edge_i) & ~($past(sens) & ~$past(sens_q))) == '0)
    else $error("edge request without a sensed rise");

  p_level_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(~edge_i & sens) & ~req_q) == '0)
    else $error("active level request dropped");

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) & ~$past(sens) & req_q) == '0)
    else $error("cleared request survived without sensed input");
endmodule

// File: rtl/pint_ctrl.sv
`timescale 1ns/1ps
module pint_ctrl #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [2*LANE_W-1:0]       port_a_i,
  input  logic [2*LANE_W-1:0]       port_b_i,
  input  logic                      wr_en_i,
  input  logic [pint_pkg::REG_AW-1:0] addr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic [LANES*LANE_W-1:0]   rdata_o,
  output logic                      irq_o
);
  import pint_pkg::*;

  localparam int DW = LANES * LANE_W;
  localparam int PW = 2 * LANE_W;

  logic [DW-1:0]   mask_q, edge_q, inv_q, asg_q;
  logic [DW-1:0]   req, lanes, clr;
  logic [2*PW-1:0] pins_s;
  logic [LANES-1:0] sel;

  function automatic logic hit(input logic [REG_AW-1:0] a, input reg_addr_e r);
    return wr_en_i && (a == r);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      edge_q <= '0;
      inv_q  <= '0;
      asg_q  <= '0;
    end else begin
      if (hit(addr_i, ADR_MSK_SET)) mask_q <= mask_q | wdata_i;
      if (hit(addr_i, ADR_MSK_CLR)) mask_q <= mask_q & ~wdata_i;
      if (hit(addr_i, ADR_EDG_SET)) edge_q <= edge_q | wdata_i;
      if (hit(addr_i, ADR_EDG_CLR)) edge_q <= edge_q & ~wdata_i;
      if (hit(addr_i, ADR_INV_SET)) inv_q  <= inv_q | wdata_i;
      if (hit(addr_i, ADR_INV_CLR)) inv_q  <= inv_q & ~wdata_i;
      if (hit(addr_i, ADR_ASG))     asg_q  <= wdata_i;
    end
  end

  assign clr = hit(addr_i, ADR_REQ) ? wdata_i : '0;

  for (genvar k = 0; k < LANES; k++) begin : g_sel
    assign sel[k] = asg_q[k*LANE_W];
  end

  pint_sync #(.W(2*PW)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({port_b_i, port_a_i}),
    .q_o    (pins_s)
  );

  pint_router #(.LANE_W(LANE_W), .LANES(LANES)) u_router (
    .port_a_i (pins_s[PW-1:0]),
    .port_b_i (pins_s[2*PW-1:PW]),
    .sel_i    (sel),
    .lanes_o  (lanes)
  );

  pint_sense #(.W(DW)) u_sense (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lanes_i (lanes),
    .edge_i  (edge_q),
    .inv_i   (inv_q),
    .clr_i   (clr),
    .req_o   (req)
  );

  always_comb begin
    case (addr_i)
      ADR_MSK_SET, ADR_MSK_CLR: rdata_o = mask_q;
      ADR_REQ:                  rdata_o = req;
      ADR_ASG:                  rdata_o = asg_q;
      ADR_EDG_SET, ADR_EDG_CLR: rdata_o = edge_q;
      ADR_INV_SET, ADR_INV_CLR: rdata_o = inv_q;
      default:                  rdata_o = '0;
    endcase
  end

  assign irq_o = |(req & mask_q);

  p_mask_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADR_MSK_SET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)))
    else $error("mask set alias failed");

  p_mask_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADR_MSK_CLR) |=> ((mask_q & $past(wdata_i)) == '0))
    else $error("mask clear alias failed");

  p_edge_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADR_EDG_SET) |=>
      ((edge_q & ~$past(wdata_i)) == ($past(edge_q) & ~$past(wdata_i))))
    else $error("edge set alias touched zero bits");

  p_irq_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o)
    else $error("interrupt with all bits masked");
endmodule

// File: tb/pint_ctrl_bench.sv
`timescale 1ns/1ps
module pint_ctrl_bench;
  localparam logic [3:0] A_MSET = 4'h0, A_MCLR = 4'h1, A_REQ = 4'h2, A_ASG = 4'h3,
                         A_ESET = 4'h4, A_ECLR = 4'h5, A_ISET = 4'h6, A_ICLR = 4'h7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] port_a = '0, port_b = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event  smp_ev;

  always #2.5 clk = ~clk;

  pint_ctrl u_pint_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .port_a_i (port_a),
    .port_b_i (port_b),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .irq_o    (irq)
  );

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(smp_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = sb_q.pop_front();
        got = it.is_irq ? {31'b0, irq} : rdata;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    #1;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> smp_ev;
    #1;
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    #1;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    -> smp_ev;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);

    // R1 reset state
    exp_rd(A_MSET, 32'h0, "R1 mask");
    exp_rd(A_REQ,  32'h0, "R1 req");
    exp_rd(A_ASG,  32'h0, "R1 assign");
    exp_rd(A_ESET, 32'h0, "R1 edge");
    exp_rd(A_ISET, 32'h0, "R1 invert");
    exp_irq(1'b0, "R1 irq");

    // R5 set/clear aliases
    wr(A_MSET, 32'hFFFF_0F0F);
    exp_rd(A_MSET, 32'hFFFF_0F0F, "R5 mask via set alias");
    exp_rd(A_MCLR, 32'hFFFF_0F0F, "R5 mask via clear alias");
    wr(A_MCLR, 32'h0000_000F);
    exp_rd(A_MSET, 32'hFFFF_0F00, "R5 mask clear keeps zeros");
    wr(A_MSET, 32'hFFFF_FFFF);
    wr(A_ESET, 32'hFFFF_FFFF);
    exp_rd(A_ECLR, 32'hFFFF_FFFF, "R5 edge readback");
    exp_rd(4'hC, 32'h0, "R5 unmapped read");
    // R4 setting invert on low pins is a rise
    wr(A_ISET, 32'h00FF_0000);
    wr(A_ICLR, 32'h000F_0000);
    exp_rd(A_ISET, 32'h00F0_0000, "R5 invert set/clear");
    exp_rd(A_REQ,  32'h00FF_0000, "R4 invert set raises request");
    exp_irq(1'b1, "R9 irq with masked-in request");
    wr(A_ICLR, 32'hFFFF_FFFF);
    wr(A_REQ,  32'hFFFF_FFFF);
    exp_rd(A_REQ, 32'h0, "R6 clear all");
    exp_irq(1'b0, "R9 irq low with no request");

    // R3 latency, R2 default routing (all lanes from port A)
    port_a = 16'h0001;
    tick(2);
    exp_rd(A_REQ, 32'h0, "R3 no request before third edge");
    tick(1);
    exp_rd(A_REQ, 32'h0001_0001, "R3/R2 request on third edge, lanes 0 and 2");
    wr(A_REQ, 32'hFFFF_FFFF);
    exp_rd(A_REQ, 32'h0, "R6 edge bit clears while pin held high");

    // R2 lanes 2,3 from port B
    port_a = '0;
    tick(3);
    wr(A_ASG, 32'h0101_0000);
    exp_rd(A_ASG, 32'h0101_0000, "R2 assign readback");
    port_b = 16'h8001;
    tick(3);
    exp_rd(A_REQ, 32'h8001_0000, "R2 port B into lanes 2 and 3");
    port_a = 16'h0100;
    tick(3);
    exp_rd(A_REQ, 32'h8001_0100, "R2 port A high half into lane 1 only");
    port_a = '0; port_b = '0;
    tick(3);
    wr(A_REQ, 32'hFFFF_FFFF);
    exp_rd(A_REQ, 32'h0, "R6 clear after routing test");

    // R4 invert: falling pin triggers
    wr(A_ISET, 32'h1);
    tick(1);
    exp_rd(A_REQ, 32'h1, "R4 invert on low pin");
    wr(A_REQ, 32'hFFFF_FFFF);
    exp_rd(A_REQ, 32'h0, "R6 clear");
    port_a = 16'h0001;
    tick(3);
    exp_rd(A_REQ, 32'h0, "R4 rising pin ignored when inverted");
    port_a = 16'h0000;
    tick(3);
    exp_rd(A_REQ, 32'h1, "R4 falling pin raises request");

    // R10 both-edge by flipping invert on acknowledge
    wr(A_ICLR, 32'h1);
    wr(A_REQ, 32'h1);
    exp_rd(A_REQ, 32'h0, "R10 flip invert with pin low, no request");
    port_a = 16'h0001;
    tick(3);
    exp_rd(A_REQ, 32'h1, "R10 rise after flip");
    wr(A_ISET, 32'h1);
    wr(A_REQ, 32'h1);
    tick(2);
    exp_rd(A_REQ, 32'h0, "R10 flip invert with pin high, no request");
    port_a = 16'h0000;
    tick(3);
    exp_rd(A_REQ, 32'h1, "R10 fall after flip");
    wr(A_ICLR, 32'h1);
    wr(A_REQ, 32'h1);

    // R7 level mode
    wr(A_ECLR, 32'h1);
    tick(2);
    exp_rd(A_REQ, 32'h0, "R7 level low no request");
    port_a = 16'h0001;
    tick(3);
    exp_rd(A_REQ, 32'h1, "R7 level high request");
    wr(A_REQ, 32'h1);
    exp_rd(A_REQ, 32'h1, "R7 clear ignored while active");
    port_a = 16'h0000;
    tick(3);
    wr(A_REQ, 32'h1);
    exp_rd(A_REQ, 32'h0, "R7 clear after deassert");
    wr(A_ESET, 32'h1);

    // R8 event beats clear in the same cycle
    port_a = 16'h0100;
    tick(3);
    exp_rd(A_REQ, 32'h0000_0100, "R8 setup bit 8");
    port_a = 16'h0101;
    tick(2);
    wr(A_REQ, 32'h0000_0101);
    exp_rd(A_REQ, 32'h0000_0001, "R8 new event kept, old bit cleared");

    // R9 mask gating
    exp_irq(1'b1, "R9 irq with mask set");
    wr(A_MCLR, 32'h1);
    exp_irq(1'b0, "R9 irq gated by mask");
    exp_rd(A_REQ, 32'h1, "R9 masked request still pending");
    wr(A_MSET, 32'h1);
    exp_irq(1'b1, "R9 irq after unmask");

    tick(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule